// File: doc/BRIEF.md
# Byte-Lane Transmit Payload Filler

This block is the transmit data source on the slave side of a byte-lane bus. Each cycle the master raises one request bit per byte lane. The block answers in the same cycle by placing consecutive bytes of its input stream into the requested lanes of its data output. It starts at the highest-numbered requested lane and works downward. The requested set may have gaps, so the bytes are scattered and not packed. Lanes that are not requested carry zero.

The input stream enters through a valid/ready handshake that delivers up to `IN_BYTES` bytes per transfer into a holding buffer of `DEPTH` bytes. Requests are served only from bytes already held in the buffer. A request for more bytes than are held raises an underrun flag for that cycle. In that case the held bytes go to the highest requested lanes and only those bytes are consumed. The lane count is 1, 2 or 4, for an 8, 16 or 32 bit data path. Frame enables and overhead markers belong to the master and are not part of this block.

Top module: `lane_tx_filler`

## Requirements
- R1: The oldest held byte appears, in the same cycle, in the highest-numbered lane whose request bit is set. Each later byte goes to the next lower requested lane, and unrequested lanes between them are skipped. Lane N occupies data bits [8N+7:8N]. With request 4'b1011, bytes 0, 1 and 2 appear in lanes 3, 1 and 0.
- R2: Every lane whose request bit is clear outputs 8'h00.
- R3: At each clock edge the block consumes min(number of set request bits, held bytes) bytes from the front of the buffer.
- R4: `underrun` is high in a cycle exactly when the number of set request bits exceeds the held byte count. In that cycle the held bytes fill the highest requested lanes, and the remaining requested lanes output 8'h00.
- R5: `in_ready` is high exactly when at least `IN_BYTES` bytes of the buffer are free. A transfer (`in_valid` and `in_ready` high) appends `in_nbytes` bytes. Byte k sits at `in_bytes[8k+7:8k]`, and byte 0 is the earliest.
- R6: A synchronous reset empties the buffer. After reset, `in_ready` is high, any nonzero request underruns, and the data output is all zero.
- R7: `in_valid` while `in_ready` is low adds no bytes to the buffer.
- R8: `LANES` must be 1, 2 or 4, and `DEPTH` must be at least `LANES` and at least `IN_BYTES`. These limits are checked at elaboration.
- R9: The held byte count never exceeds `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input transfer offered |
| in_nbytes | input | $clog2(IN_BYTES+1) | Number of bytes in the transfer, 1 to IN_BYTES |
| in_bytes | input | 8*IN_BYTES | Transfer bytes, byte 0 (earliest) in the low bits |
| in_ready | output | 1 | Buffer can take a full transfer |
| txena | input | LANES | Per-lane payload byte request from the master |
| txdat | output | 8*LANES | Lane data toward the master |
| underrun | output | 1 | Request exceeds held bytes this cycle |

## Verification
The bench builds the block with LANES=4, DEPTH=8 and IN_BYTES=4. This setting reaches all sixteen request patterns, including gapped ones such as 4'b1011 and 4'b0101. A buffer of two transfers can fill completely, so `in_ready` drops, and offers made while it is low show whether any bytes slip in. Random request and transfer sizes repeatedly drive the held count between empty and full, which covers both partial underruns and a reset applied in the middle of a run.

// File: rtl/lane_fill_pkg.sv
package lane_fill_pkg;
   typedef logic [7:0] lane_byte_t;

   function automatic bit lane_count_ok(input int n);
      return (n == 1) || (n == 2) || (n == 4);
   endfunction
endpackage

// File: rtl/lane_rank.sv
// Counts, for each lane, the requested lanes above it (its slot in the stream),
// and the total number of requested lanes.
module lane_rank #(
   parameter int LANES = 4,
   parameter int CW    = 4
) (
   input  logic [LANES-1:0]         req,
   output logic [LANES-1:0][CW-1:0] rank,
   output logic [CW-1:0]            total
);
   for (genvar l = 0; l < LANES; l++) begin : g_rank
      if (l == LANES-1) begin : g_top
         assign rank[l] = '0;
      end else begin : g_below
         assign rank[l] = rank[l+1] + CW'(req[l+1]);
      end
   end
   assign total = rank[0] + CW'(req[0]);
endmodule

// File: rtl/byte_hold_buf.sv
// Holding buffer kept front-aligned: entry 0 is always the oldest byte.
module byte_hold_buf
   import lane_fill_pkg::*;
#(
   parameter int DEPTH    = 8,
   parameter int IN_BYTES = 4,
   parameter int CW       = 4,
   parameter int NW       = 3
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             add_en,
   input  logic [NW-1:0]                    add_n,
   input  logic [IN_BYTES-1:0][7:0]         add_bytes,
   input  logic [CW-1:0]                    take_n,
   output lane_byte_t [DEPTH-1:0]           held,
   output logic [CW-1:0]                    occ
);
   lane_byte_t [DEPTH-1:0] held_nx;
   logic [CW-1:0]          add_cnt;

   always_comb begin
      if (!add_en)
         add_cnt = '0;
      else if (int'(add_n) > IN_BYTES)
         add_cnt = CW'(IN_BYTES);
      else
         add_cnt = CW'(add_n);
   end

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         int src;
         src = i + int'(take_n);
         held_nx[i] = 8'h00;
         if (src < int'(occ)) begin
            for (int s = 0; s < DEPTH; s++)
               if (s == src) held_nx[i] = held[s];
         end else begin
            for (int k = 0; k < IN_BYTES; k++)
               if (k == src - int'(occ) && k < int'(add_cnt)) held_nx[i] = add_bytes[k];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         occ  <= '0;
         held <= '0;
      end else begin
         occ  <= occ - take_n + add_cnt;
         held <= held_nx;
      end
   end
endmodule

// File: rtl/tx_lane_mux.sv
// Places held byte number rank[l] on lane l when that lane is requested and
// the byte exists; otherwise the lane carries zero.
module tx_lane_mux
   import lane_fill_pkg::*;
#(
   parameter int LANES = 4,
   parameter int CW    = 4
) (
   input  logic [LANES-1:0]         req,
   input  logic [LANES-1:0][CW-1:0] rank,
   input  logic [CW-1:0]            occ,
   input  lane_byte_t [LANES-1:0]   front,
   output logic [8*LANES-1:0]       lane_data
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      lane_byte_t pick;
      always_comb begin
         pick = 8'h00;
         if (req[l] && rank[l] < occ) begin
            for (int k = 0; k < LANES; k++)
               if (int'(rank[l]) == k) pick = front[k];
         end
      end
      assign lane_data[8*l +: 8] = pick;
   end
endmodule

// File: rtl/lane_tx_filler.sv
module lane_tx_filler
   import lane_fill_pkg::*;
#(
   parameter int LANES    = 4,
   parameter int DEPTH    = 8,
   parameter int IN_BYTES = 4,
   localparam int CW      = $clog2(DEPTH + 1),
   localparam int NW      = $clog2(IN_BYTES + 1)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  in_valid,
   input  logic [NW-1:0]         in_nbytes,
   input  logic [8*IN_BYTES-1:0] in_bytes,
   output logic                  in_ready,
   input  logic [LANES-1:0]      txena,
   output logic [8*LANES-1:0]    txdat,
   output logic                  underrun
);
   // R8: elaboration-time parameter checks
   if (!lane_count_ok(LANES)) begin : g_bad_lanes
      $error("LANES must be 1, 2 or 4");
   end
   if (DEPTH < LANES || DEPTH < IN_BYTES) begin : g_bad_depth
      $error("DEPTH must cover LANES and IN_BYTES");
   end

   logic [LANES-1:0][CW-1:0] rank;
   logic [CW-1:0]            req_total;
   logic [CW-1:0]            occ;
   logic [CW-1:0]            take_n;
   lane_byte_t [DEPTH-1:0]   held;
   lane_byte_t [LANES-1:0]   front;
   logic                     add_en;

   lane_rank #(.LANES(LANES), .CW(CW)) u_rank (
      .req   (txena),
      .rank  (rank),
      .total (req_total)
   );

   assign underrun = req_total > occ;
   assign take_n   = underrun ? occ : req_total;
   assign in_ready = int'(occ) <= DEPTH - IN_BYTES;
   assign add_en   = in_valid && in_ready;

   byte_hold_buf #(.DEPTH(DEPTH), .IN_BYTES(IN_BYTES), .CW(CW), .NW(NW)) u_buf (
      .clk       (clk),
      .rst       (rst),
      .add_en    (add_en),
      .add_n     (in_nbytes),
      .add_bytes (in_bytes),
      .take_n    (take_n),
      .held      (held),
      .occ       (occ)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_front
      assign front[k] = held[k];
   end

   tx_lane_mux #(.LANES(LANES), .CW(CW)) u_mux (
      .req       (txena),
      .rank      (rank),
      .occ       (occ),
      .front     (front),
      .lane_data (txdat)
   );
endmodule

// File: rtl/lane_tx_filler_chk.sv
module lane_tx_filler_chk #(
   parameter int LANES    = 4,
   parameter int DEPTH    = 8,
   parameter int IN_BYTES = 4,
   parameter int CW       = 4
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  in_valid,
   input logic                  in_ready,
   input logic [LANES-1:0]      txena,
   input logic [8*LANES-1:0]    txdat,
   input logic                  underrun,
   input logic [CW-1:0]         occ
);
   for (genvar l = 0; l < LANES; l++) begin : g_zero
      assert_idle_lane_zero_R2: assert property (@(posedge clk) disable iff (rst)
         !txena[l] |-> txdat[8*l +: 8] == 8'h00);
   end

   assert_occ_bound_R9: assert property (@(posedge clk) disable iff (rst)
      int'(occ) <= DEPTH);

   assert_reset_empties_R6: assert property (@(posedge clk)
      rst |=> occ == '0);

   assert_ready_room_R5: assert property (@(posedge clk) disable iff (rst)
      in_ready |-> int'(occ) + IN_BYTES <= DEPTH);

   assert_underrun_needs_req_R4: assert property (@(posedge clk) disable iff (rst)
      underrun |-> txena != '0);

   assert_idle_keeps_occ_R3: assert property (@(posedge clk) disable iff (rst)
      (txena == '0 && !(in_valid && in_ready)) |=> $stable(occ));

   assert_blocked_offer_R7: assert property (@(posedge clk) disable iff (rst)
      (!in_ready && txena == '0) |=> $stable(occ));
endmodule

bind lane_tx_filler lane_tx_filler_chk #(
   .LANES(LANES), .DEPTH(DEPTH), .IN_BYTES(IN_BYTES), .CW(CW)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .txena    (txena),
   .txdat    (txdat),
   .underrun (underrun),
   .occ      (occ)
);

// File: tb/lane_tx_filler_tb_top.sv
module lane_tx_filler_tb_top;
   localparam int CLK_P    = 10;
   localparam int LANES    = 4;
   localparam int DEPTH    = 8;
   localparam int IN_BYTES = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [2:0]  in_nbytes = 3'd0;
   logic [31:0] in_bytes = '0;
   logic        in_ready;
   logic [3:0]  txena = '0;
   logic [31:0] txdat;
   logic        underrun;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;
   logic [7:0] q[$];
   logic [7:0] seq = 8'h10;

   always #(CLK_P/2) clk = ~clk;

   lane_tx_filler #(.LANES(LANES), .DEPTH(DEPTH), .IN_BYTES(IN_BYTES)) dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_nbytes(in_nbytes),
      .in_bytes(in_bytes), .in_ready(in_ready), .txena(txena),
      .txdat(txdat), .underrun(underrun)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // One cycle: drive at the falling edge, compare settled outputs, then advance the model.
   task automatic step(input logic r, input logic [3:0] ena, input logic v, input int n, input string ph);
      int pos, pop, take;
      logic exp_rdy, exp_und;
      logic [7:0] lane_exp;
      @(negedge clk);
      rst = r; txena = ena; in_valid = v; in_nbytes = 3'(n);
      in_bytes = {seq + 8'd3, seq + 8'd2, seq + 8'd1, seq};
      #1;
      exp_rdy = (DEPTH - q.size()) >= IN_BYTES;
      pop = 0;
      for (int l = 0; l < LANES; l++) pop += ena[l];
      exp_und = pop > q.size();
      check({ph, " R5 in_ready"}, {31'd0, in_ready}, {31'd0, exp_rdy});
      check({ph, " R4 underrun"}, {31'd0, underrun}, {31'd0, exp_und});
      pos = 0;
      for (int l = LANES-1; l >= 0; l--) begin
         lane_exp = 8'h00;
         if (ena[l]) begin
            if (pos < q.size()) lane_exp = q[pos];
            pos++;
            check({ph, exp_und ? " R4 lane" : " R1 lane"}, {24'd0, txdat[8*l +: 8]}, {24'd0, lane_exp});
         end else begin
            check({ph, " R2 idle lane"}, {24'd0, txdat[8*l +: 8]}, 32'd0);
         end
      end
      if (r) begin
         q.delete();                       // R6
      end else begin
         take = (pop < q.size()) ? pop : q.size();   // R3
         for (int k = 0; k < take; k++) void'(q.pop_front());
         if (v && exp_rdy) begin           // R7: no push when not ready
            for (int k = 0; k < n; k++) q.push_back(seq + 8'(k));
            seq = seq + 8'(n);
         end
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      q.delete();
      step(1, 4'h0, 0, 0, "rst");
      step(1, 4'h0, 0, 0, "rst");
      // R6: empty after reset
      step(0, 4'hF, 0, 0, "R6 empty");
      // R5: fill to full, then R7: offers while not ready
      step(0, 4'h0, 1, 4, "R5 fill");
      step(0, 4'h0, 1, 4, "R5 fill");
      step(0, 4'h0, 1, 3, "R7 blocked");
      step(0, 4'h0, 1, 2, "R7 blocked");
      // R1: gapped pattern 1011, then others
      step(0, 4'b1011, 0, 0, "R1 gap1011");
      step(0, 4'b0101, 0, 0, "R1 gap0101");
      step(0, 4'b1000, 0, 0, "R1 single");
      // R4: partial underrun (2 bytes left, 4 requested)
      step(0, 4'b1111, 0, 0, "R4 partial");
      step(0, 4'b0110, 0, 0, "R4 empty");
      // R5: odd transfer sizes, R3 consumption across cycles
      step(0, 4'b0000, 1, 1, "R5 n1");
      step(0, 4'b1001, 1, 3, "R3 mix");
      step(0, 4'b0111, 1, 2, "R3 mix");
      step(0, 4'b1110, 0, 0, "R3 mix");
      for (int c = 0; c < 4000; c++) begin
         logic rr;
         rr = ($urandom_range(0, 199) == 0);
         step(rr, 4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
              $urandom_range(1, IN_BYTES), "rand");
      end
      // R6: reset with data held
      step(0, 4'h0, 1, 4, "R6 pre");
      step(1, 4'h0, 1, 4, "R6 mid");
      step(0, 4'b0011, 0, 0, "R6 after");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule